// File: doc/BRIEF.md
# Standby Power-State Sequencer

This block sequences the low-power states of a small microcontroller core. From run mode the CPU asks for one of three standby depths: a light halt, where only instruction execution stops; a deep hold, where execution, all peripherals and every oscillator stop; and a crystal-hold, where the fast oscillators and most peripherals stop but the base timer runs and the crystal oscillator keeps the state it had when the mode was entered. The block drives the gating outputs for each domain. It watches the wake sources and returns the core to run.

Each depth has its own set of wake sources. Halt wakes on any interrupt. Hold wakes on a subset of the external lines and on the port-0 interrupt. Crystal-hold adds the base-timer and calendar-counter interrupts. Two of the external lines can wake the deep modes only when they are configured for level detection. An exit caused by the reset pin or by the watchdog passes through a one-cycle system reset pulse. After a deep mode, the CPU stays stopped for a programmable settling count while the oscillators restart. The most recent wake cause is held in an output register.

Top module: `stby_ctrl`

## Requirements
- R1: After `rst_n` is released and before any request, `cpu_run`, `periph_clk_en`, `btimer_en` and all three fast-oscillator enables are 1, `osc_xt_en` follows `xtal_run_en`, `sys_rst` and `req_reject` are 0, and `wake_cause` reads 7 (no wake yet).
- R2: A request is taken from run mode when `req_valid` is 1. `req_mode` is encoded 2'b01 halt, 2'b10 hold, 2'b11 crystal-hold. The code 2'b00 has no effect. The chosen mode is in force from the clock edge that samples the request.
- R3: In halt, `cpu_run` is 0. `periph_clk_en`, `btimer_en` and the fast-oscillator enables stay 1, and `osc_xt_en` follows `xtal_run_en`.
- R4: Halt exits on `pin_rst_n` low, on `wdt_rst`, or on any interrupt (any `ext_irq` line whatever its detection mode, `p0_irq`, `bt_irq`, `cal_irq`). An interrupt exit gives `cpu_run` 1 at the edge that samples the wake, with no settling interval.
- R5: In hold, every gating output (`cpu_run`, `periph_clk_en`, `btimer_en`, the three fast-oscillator enables and `osc_xt_en`) is 0.
- R6: Hold wakes on reset pin, watchdog, `ext_irq` lines 2, 4, 5, 6, 7 and `p0_irq`. Line 3, `bt_irq` and `cal_irq` leave it in hold.
- R7: `ext_irq` lines 0 and 1 wake hold or crystal-hold only while their `ext_level` bit is 1 (level detection). With the bit at 0 they are ignored in those modes.
- R8: In crystal-hold, `cpu_run`, `periph_clk_en` and the fast-oscillator enables are 0, `btimer_en` is 1, and `osc_xt_en` holds the value `xtal_run_en` had when the request was taken, even if `xtal_run_en` changes later.
- R9: Crystal-hold wakes on every hold wake source and also on `bt_irq` and `cal_irq`.
- R10: A reset-pin or watchdog exit raises `sys_rst` for exactly one cycle with `cpu_run` 0. `cpu_run` returns to 1 in the next cycle. An interrupt exit never raises `sys_rst`.
- R11: On exit from hold or crystal-hold, the fast oscillators are enabled at once. `osc_xt_en` follows `xtal_run_en`. `cpu_run` and `periph_clk_en` stay 0 for `stab_cycles`+1 cycles before run (or the reset pulse) resumes.
- R12: A request whose own wake set is already active is rejected. `req_reject` is 1 for one cycle and the block stays in run.
- R13: On each exit `wake_cause` is set to the highest-priority active source of that mode: 0 reset pin, 1 watchdog, 2 external line, 3 port 0, 4 base timer, 5 calendar counter. The lower code wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| req_valid | input | 1 | Standby request strobe |
| req_mode | input | 2 | Requested depth (01 halt, 10 hold, 11 crystal-hold) |
| xtal_run_en | input | 1 | Crystal oscillator enable wanted in run |
| stab_cycles | input | STAB_W | Settling count after a deep-mode exit |
| pin_rst_n | input | 1 | External reset pin, active low |
| wdt_rst | input | 1 | Watchdog system reset request |
| ext_irq | input | N_EXT | External interrupt lines |
| ext_level | input | N_EXT | Per-line detection mode, 1 = level |
| p0_irq | input | 1 | Port-0 interrupt |
| bt_irq | input | 1 | Base-timer interrupt |
| cal_irq | input | 1 | Calendar-counter interrupt |
| cpu_run | output | 1 | CPU execution enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_cf_en | output | 1 | Ceramic oscillator enable |
| osc_rc_en | output | 1 | Internal RC oscillator enable |
| osc_vrc_en | output | 1 | Variable RC oscillator enable |
| osc_xt_en | output | 1 | Crystal oscillator enable |
| btimer_en | output | 1 | Base-timer enable |
| sys_rst | output | 1 | System reset pulse on reset-type exit |
| req_reject | output | 1 | One-cycle pulse when a request is refused |
| wake_cause | output | 3 | Most recent wake cause code |

## Verification
The bench checks the wake-set boundaries of each depth. Line 3, the base timer and the calendar interrupt must not end hold, while the same base-timer and calendar interrupts do end crystal-hold. A design that used one wake set for all depths would wake early or stay asleep. Lines 0 and 1 are toggled in edge and in level mode, which catches a design that ignores the detection setting. The crystal enable is changed during crystal-hold to catch a design that tracks the live setting instead of the value latched at entry. The bench counts the settling interval exactly for a nonzero count and a zero count, so an off-by-one counter shows up. Simultaneous sources check the cause priority, and requests made while a source is pending check that they are rejected rather than entering a mode they cannot leave cleanly.

// File: rtl/stby_pkg.sv
package stby_pkg;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_HALT  = 3'd1,
        ST_HOLD  = 3'd2,
        ST_XHOLD = 3'd3,
        ST_STAB  = 3'd4,
        ST_RST   = 3'd5
    } stby_state_e;

    localparam logic [1:0] REQ_NONE  = 2'b00;
    localparam logic [1:0] REQ_HALT  = 2'b01;
    localparam logic [1:0] REQ_HOLD  = 2'b10;
    localparam logic [1:0] REQ_XHOLD = 2'b11;

    localparam logic [2:0] CAUSE_PIN  = 3'd0;
    localparam logic [2:0] CAUSE_WDT  = 3'd1;
    localparam logic [2:0] CAUSE_EXT  = 3'd2;
    localparam logic [2:0] CAUSE_P0   = 3'd3;
    localparam logic [2:0] CAUSE_BT   = 3'd4;
    localparam logic [2:0] CAUSE_CAL  = 3'd5;
    localparam logic [2:0] CAUSE_NONE = 3'd7;

    typedef struct packed {
        logic cpu;
        logic periph;
        logic fast_osc;
        logic xt;
        logic btmr;
        logic sysrst;
    } gate_t;

endpackage

// File: rtl/stby_wake.sv
module stby_wake #(
    parameter int              N_EXT      = 8,
    parameter logic [N_EXT-1:0] DEEP_MASK  = 8'b1111_0111,
    parameter logic [N_EXT-1:0] LEVEL_ONLY = 8'b0000_0011
) (
    input  logic             pin_rst_n,
    input  logic             wdt_rst,
    input  logic [N_EXT-1:0] ext_irq,
    input  logic [N_EXT-1:0] ext_level,
    input  logic             p0_irq,
    input  logic             bt_irq,
    input  logic             cal_irq,
    output logic             rst_src,
    output logic             wake_halt,
    output logic             wake_hold,
    output logic             wake_xhold,
    output logic [2:0]       cause_halt,
    output logic [2:0]       cause_hold,
    output logic [2:0]       cause_xhold
);
    import stby_pkg::*;

    logic [N_EXT-1:0] ext_deep;
    logic             ext_any;
    logic             ext_deep_any;

    // per-line qualification for the deep modes
    for (genvar gi = 0; gi < N_EXT; gi++) begin : g_line
        assign ext_deep[gi] = ext_irq[gi] & DEEP_MASK[gi]
                            & (~LEVEL_ONLY[gi] | ext_level[gi]);
    end

    function automatic logic [2:0] pick_cause(
        input logic pin, input logic wdt, input logic ext,
        input logic p0,  input logic bt,  input logic cal);
        logic [2:0] c;
        c = CAUSE_NONE;
        if (cal) c = CAUSE_CAL;
        if (bt)  c = CAUSE_BT;
        if (p0)  c = CAUSE_P0;
        if (ext) c = CAUSE_EXT;
        if (wdt) c = CAUSE_WDT;
        if (pin) c = CAUSE_PIN;
        return c;
    endfunction

    always_comb begin
        ext_any      = |ext_irq;
        ext_deep_any = |ext_deep;
        rst_src      = ~pin_rst_n | wdt_rst;
        wake_halt    = rst_src | ext_any | p0_irq | bt_irq | cal_irq;
        wake_hold    = rst_src | ext_deep_any | p0_irq;
        wake_xhold   = wake_hold | bt_irq | cal_irq;
        cause_halt   = pick_cause(~pin_rst_n, wdt_rst, ext_any, p0_irq, bt_irq, cal_irq);
        cause_hold   = pick_cause(~pin_rst_n, wdt_rst, ext_deep_any, p0_irq, 1'b0, 1'b0);
        cause_xhold  = pick_cause(~pin_rst_n, wdt_rst, ext_deep_any, p0_irq, bt_irq, cal_irq);
    end

endmodule

// File: rtl/stby_stab_cnt.sv
module stby_stab_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         en,
    output logic         done
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (en && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);

    // R11
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));

    // R11
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load && cnt_q != '0) |=> (cnt_q == W'($past(cnt_q) - 1'b1)));

endmodule

// File: rtl/stby_gate.sv
module stby_gate (
    input  stby_pkg::stby_state_e state,
    input  logic                  xt_run,
    input  logic                  xt_held,
    output stby_pkg::gate_t       gate
);
    import stby_pkg::*;

    always_comb begin
        gate = '0;
        unique case (state)
            ST_RUN: begin
                gate.cpu = 1'b1; gate.periph = 1'b1; gate.fast_osc = 1'b1;
                gate.xt  = xt_run; gate.btmr = 1'b1;
            end
            ST_HALT: begin
                gate.periph = 1'b1; gate.fast_osc = 1'b1;
                gate.xt = xt_run; gate.btmr = 1'b1;
            end
            ST_HOLD: begin
                gate = '0;
            end
            ST_XHOLD: begin
                gate.xt = xt_held; gate.btmr = 1'b1;
            end
            ST_STAB: begin
                gate.fast_osc = 1'b1; gate.xt = xt_run;
            end
            ST_RST: begin
                gate.fast_osc = 1'b1; gate.xt = xt_run; gate.sysrst = 1'b1;
            end
            default: gate = '0;
        endcase
    end

endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl #(
    parameter int               N_EXT      = 8,
    parameter int               STAB_W     = 8,
    parameter logic [N_EXT-1:0] DEEP_MASK  = 8'b1111_0111,
    parameter logic [N_EXT-1:0] LEVEL_ONLY = 8'b0000_0011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_mode,
    input  logic              xtal_run_en,
    input  logic [STAB_W-1:0] stab_cycles,
    input  logic              pin_rst_n,
    input  logic              wdt_rst,
    input  logic [N_EXT-1:0]  ext_irq,
    input  logic [N_EXT-1:0]  ext_level,
    input  logic              p0_irq,
    input  logic              bt_irq,
    input  logic              cal_irq,
    output logic              cpu_run,
    output logic              periph_clk_en,
    output logic              osc_cf_en,
    output logic              osc_rc_en,
    output logic              osc_vrc_en,
    output logic              osc_xt_en,
    output logic              btimer_en,
    output logic              sys_rst,
    output logic              req_reject,
    output logic [2:0]        wake_cause
);
    import stby_pkg::*;

    typedef struct packed {
        stby_state_e state;
        logic        xt_held;
        logic        rst_pend;
        logic [2:0]  cause;
        logic        reject;
    } ctl_t;

    ctl_t  cur_q, nxt_d;
    logic  rst_src, wake_halt, wake_hold, wake_xhold;
    logic [2:0] cause_halt, cause_hold, cause_xhold;
    logic  stab_load, stab_en, stab_done;
    logic  req_pending;
    gate_t gate;

    stby_wake #(
        .N_EXT(N_EXT), .DEEP_MASK(DEEP_MASK), .LEVEL_ONLY(LEVEL_ONLY)
    ) u_wake (
        .pin_rst_n  (pin_rst_n),
        .wdt_rst    (wdt_rst),
        .ext_irq    (ext_irq),
        .ext_level  (ext_level),
        .p0_irq     (p0_irq),
        .bt_irq     (bt_irq),
        .cal_irq    (cal_irq),
        .rst_src    (rst_src),
        .wake_halt  (wake_halt),
        .wake_hold  (wake_hold),
        .wake_xhold (wake_xhold),
        .cause_halt (cause_halt),
        .cause_hold (cause_hold),
        .cause_xhold(cause_xhold)
    );

    stby_stab_cnt #(.W(STAB_W)) u_stab (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (stab_load),
        .load_val(stab_cycles),
        .en      (stab_en),
        .done    (stab_done)
    );

    always_comb begin
        unique case (req_mode)
            REQ_HALT:  req_pending = wake_halt;
            REQ_HOLD:  req_pending = wake_hold;
            REQ_XHOLD: req_pending = wake_xhold;
            default:   req_pending = 1'b0;
        endcase
    end

    always_comb begin
        nxt_d        = cur_q;
        nxt_d.reject = 1'b0;
        stab_load    = 1'b0;
        stab_en      = (cur_q.state == ST_STAB);
        unique case (cur_q.state)
            ST_RUN: begin
                if (req_valid && req_mode != REQ_NONE) begin
                    if (req_pending) begin
                        nxt_d.reject = 1'b1;
                    end else begin
                        nxt_d.xt_held = xtal_run_en;
                        unique case (req_mode)
                            REQ_HALT: nxt_d.state = ST_HALT;
                            REQ_HOLD: nxt_d.state = ST_HOLD;
                            default:  nxt_d.state = ST_XHOLD;
                        endcase
                    end
                end
            end
            ST_HALT: begin
                if (wake_halt) begin
                    nxt_d.cause = cause_halt;
                    nxt_d.state = rst_src ? ST_RST : ST_RUN;
                end
            end
            ST_HOLD: begin
                if (wake_hold) begin
                    nxt_d.cause    = cause_hold;
                    nxt_d.rst_pend = rst_src;
                    nxt_d.state    = ST_STAB;
                    stab_load      = 1'b1;
                end
            end
            ST_XHOLD: begin
                if (wake_xhold) begin
                    nxt_d.cause    = cause_xhold;
                    nxt_d.rst_pend = rst_src;
                    nxt_d.state    = ST_STAB;
                    stab_load      = 1'b1;
                end
            end
            ST_STAB: begin
                if (stab_done) begin
                    nxt_d.state    = cur_q.rst_pend ? ST_RST : ST_RUN;
                    nxt_d.rst_pend = 1'b0;
                end
            end
            ST_RST: begin
                nxt_d.state = ST_RUN;
            end
            default: nxt_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state    <= ST_RUN;
            cur_q.xt_held  <= 1'b0;
            cur_q.rst_pend <= 1'b0;
            cur_q.cause    <= CAUSE_NONE;
            cur_q.reject   <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    stby_gate u_gate (
        .state  (cur_q.state),
        .xt_run (xtal_run_en),
        .xt_held(cur_q.xt_held),
        .gate   (gate)
    );

    assign cpu_run       = gate.cpu;
    assign periph_clk_en = gate.periph;
    assign osc_cf_en     = gate.fast_osc;
    assign osc_rc_en     = gate.fast_osc;
    assign osc_vrc_en    = gate.fast_osc;
    assign osc_xt_en     = gate.xt;
    assign btimer_en     = gate.btmr;
    assign sys_rst       = gate.sysrst;
    assign req_reject    = cur_q.reject;
    assign wake_cause    = cur_q.cause;

    // R12
    reject_stays_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_reject |-> cpu_run);

    // R10
    sysrst_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |=> (!sys_rst && cpu_run));

    // R8
    xhold_xt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_XHOLD && $past(cur_q.state) == ST_XHOLD) |-> $stable(osc_xt_en));

    // R3
    halt_osc_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_run && periph_clk_en) |-> (osc_cf_en && osc_rc_en && osc_vrc_en));

    // R11
    stab_cpu_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_STAB) |-> (!cpu_run && osc_cf_en && !periph_clk_en));

endmodule

// File: tb/tb_stby_ctrl.sv
`timescale 1ns/1ps
module tb_stby_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_mode = 2'b00;
    logic       xtal_run_en = 1'b1;
    logic [7:0] stab_cycles = 8'd0;
    logic       pin_rst_n = 1'b1;
    logic       wdt_rst = 1'b0;
    logic [7:0] ext_irq = 8'h00;
    logic [7:0] ext_level = 8'h00;
    logic       p0_irq = 1'b0, bt_irq = 1'b0, cal_irq = 1'b0;
    logic       cpu_run, periph_clk_en, osc_cf_en, osc_rc_en, osc_vrc_en;
    logic       osc_xt_en, btimer_en, sys_rst, req_reject;
    logic [2:0] wake_cause;

    always #2 clk = ~clk;

    stby_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .xtal_run_en(xtal_run_en), .stab_cycles(stab_cycles),
        .pin_rst_n(pin_rst_n), .wdt_rst(wdt_rst), .ext_irq(ext_irq),
        .ext_level(ext_level), .p0_irq(p0_irq), .bt_irq(bt_irq), .cal_irq(cal_irq),
        .cpu_run(cpu_run), .periph_clk_en(periph_clk_en), .osc_cf_en(osc_cf_en),
        .osc_rc_en(osc_rc_en), .osc_vrc_en(osc_vrc_en), .osc_xt_en(osc_xt_en),
        .btimer_en(btimer_en), .sys_rst(sys_rst), .req_reject(req_reject),
        .wake_cause(wake_cause)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    typedef struct { int cause; bit rst; } exit_t;
    exit_t exp_q[$];

    task automatic chk(string req, string what, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: got=%0d exp=%0d", req, what, got, exp);
        end
    endtask

    // monitor: pops the expected exit when run resumes
    bit prev_run = 1'b1;
    bit rst_seen = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (sys_rst) rst_seen = 1'b1;
            if (cpu_run && !prev_run) begin
                if (exp_q.size() == 0) begin
                    chk("R13", "unexpected exit", 1, 0);
                end else begin
                    exit_t e;
                    e = exp_q.pop_front();
                    chk("R13", "wake_cause at exit", int'(wake_cause), e.cause);
                    chk("R10", "reset pulse seen", int'(rst_seen), int'(e.rst));
                end
                rst_seen = 1'b0;
            end
            prev_run = cpu_run;
        end
    end

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic request(logic [1:0] m);
        @(negedge clk);
        req_valid = 1'b1; req_mode = m;
        @(negedge clk);
        req_valid = 1'b0; req_mode = 2'b00;
    endtask

    task automatic idle_wake();
        pin_rst_n = 1'b1; wdt_rst = 1'b0; ext_irq = 8'h00;
        p0_irq = 1'b0; bt_irq = 1'b0; cal_irq = 1'b0;
    endtask

    task automatic push(int c, bit r);
        exit_t e;
        e.cause = c; e.rst = r;
        exp_q.push_back(e);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got=hung exp=done");
        finish_run();
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        // R1 reset state
        chk("R1", "cpu_run", cpu_run, 1);
        chk("R1", "periph", periph_clk_en, 1);
        chk("R1", "fast osc", osc_cf_en & osc_rc_en & osc_vrc_en, 1);
        chk("R1", "xt", osc_xt_en, 1);
        chk("R1", "btimer", btimer_en, 1);
        chk("R1", "sys_rst", sys_rst, 0);
        chk("R1", "cause", wake_cause, 7);

        // R2 mode code 00 does nothing
        request(2'b00);
        chk("R2", "none keeps run", cpu_run, 1);
        chk("R2", "none not rejected", req_reject, 0);

        // R3/R4 halt, woken by edge-mode line 3
        request(2'b01);
        chk("R3", "halt cpu", cpu_run, 0);
        chk("R3", "halt periph", periph_clk_en, 1);
        chk("R3", "halt osc", osc_cf_en & osc_vrc_en & osc_xt_en & btimer_en, 1);
        ext_irq = 8'h08; push(2, 0);
        step(); idle_wake();
        chk("R4", "halt irq exit direct", cpu_run, 1);

        // R5/R6/R7/R11 hold, stab 3
        stab_cycles = 8'd3; ext_level = 8'h00;
        request(2'b10);
        chk("R5", "hold cpu", cpu_run, 0);
        chk("R5", "hold periph", periph_clk_en, 0);
        chk("R5", "hold osc", osc_cf_en | osc_rc_en | osc_vrc_en | osc_xt_en, 0);
        chk("R5", "hold btimer", btimer_en, 0);
        ext_irq = 8'h03; step(2);
        chk("R7", "edge line0/1 ignored in hold", cpu_run | osc_cf_en, 0);
        ext_irq = 8'h08; bt_irq = 1'b1; cal_irq = 1'b1; step(2);
        chk("R6", "line3/bt/cal ignored in hold", cpu_run | osc_cf_en, 0);
        idle_wake();
        p0_irq = 1'b1; push(3, 0);
        step(); idle_wake();
        chk("R11", "stab osc on", osc_cf_en & osc_rc_en & osc_vrc_en, 1);
        chk("R11", "stab xt follows run", osc_xt_en, 1);
        chk("R11", "stab cpu off", cpu_run | periph_clk_en, 0);
        step(3);
        chk("R11", "still settling at count", cpu_run, 0);
        step();
        chk("R11", "run after count+1", cpu_run, 1);

        // R7 level-mode line 0 wakes hold, stab 0
        stab_cycles = 8'd0; ext_level = 8'h01;
        request(2'b10);
        ext_irq = 8'h01; push(2, 0);
        step(); idle_wake();
        chk("R11", "zero count stab", cpu_run, 0);
        step();
        chk("R7", "level line0 woke hold", cpu_run, 1);

        // R6 line 2 wakes hold
        request(2'b10);
        ext_irq = 8'h04; push(2, 0);
        step(2); idle_wake();
        chk("R6", "line2 woke hold", cpu_run, 1);

        // R8/R9 crystal-hold with crystal on, change setting, cal wake
        xtal_run_en = 1'b1;
        request(2'b11);
        chk("R8", "xhold cpu/periph", cpu_run | periph_clk_en, 0);
        chk("R8", "xhold fast osc", osc_cf_en | osc_rc_en | osc_vrc_en, 0);
        chk("R8", "xhold btimer", btimer_en, 1);
        xtal_run_en = 1'b0; step(2);
        chk("R8", "xt latched on", osc_xt_en, 1);
        xtal_run_en = 1'b1;
        cal_irq = 1'b1; push(5, 0);
        step(2); idle_wake();
        chk("R9", "cal woke xhold", cpu_run, 1);

        // R8/R9 crystal-hold with crystal off, bt wake
        xtal_run_en = 1'b0;
        request(2'b11);
        xtal_run_en = 1'b1; step();
        chk("R8", "xt latched off", osc_xt_en, 0);
        bt_irq = 1'b1; push(4, 0);
        step(2); idle_wake();
        chk("R9", "bt woke xhold", cpu_run, 1);

        // R13 priority: p0 beats bt and cal
        request(2'b11);
        p0_irq = 1'b1; bt_irq = 1'b1; cal_irq = 1'b1; push(3, 0);
        step(); idle_wake();
        chk("R13", "p0 over bt/cal", wake_cause, 3);
        step();

        // R10 halt watchdog exit
        request(2'b01);
        wdt_rst = 1'b1; push(1, 1);
        step(); idle_wake();
        chk("R10", "sys_rst pulse", sys_rst, 1);
        chk("R10", "cpu off in pulse", cpu_run, 0);
        step();
        chk("R10", "pulse ends", sys_rst, 0);

        // R10/R13 hold exit via pin with watchdog together
        request(2'b10);
        pin_rst_n = 1'b0; wdt_rst = 1'b1; push(0, 1);
        step(); idle_wake();
        chk("R10", "no pulse during stab", sys_rst, 0);
        step();
        chk("R10", "pulse after stab", sys_rst, 1);
        chk("R13", "pin over watchdog", wake_cause, 0);
        step();

        // R12 reject requests with pending wake
        p0_irq = 1'b1;
        request(2'b10);
        chk("R12", "hold rejected", req_reject, 1);
        chk("R12", "stays run", cpu_run, 1);
        idle_wake(); ext_irq = 8'h08;
        request(2'b01);
        chk("R12", "halt rejected on line3", req_reject, 1);
        step();
        chk("R12", "reject one cycle", req_reject, 0);
        request(2'b10);
        chk("R12", "hold accepted with line3", req_reject | cpu_run, 0);
        idle_wake(); p0_irq = 1'b1; push(3, 0);
        step(2); idle_wake();
        chk("R6", "p0 woke hold", cpu_run, 1);

        step(3);
        chk("R13", "all exits seen", exp_q.size(), 0);
        finish_run();
    end

endmodule